// File: doc/BRIEF.md
# CAN Receive Acceptance Filter and Buffer Steering

This block sits after a CAN message assembly stage. For each completed frame it decides whether the frame is kept, and if it is kept, which of two receive buffers gets it. The frame arrives as a one-cycle `frm_valid` pulse with its identifier, its extended-format flag and a flag that marks a frame that ended in error. Buffer 0 owns one mask and the low filters. Buffer 1 owns a second mask and the remaining filters. Each filter can be set to match only standard or only extended frames. Each buffer also has a two-bit receive mode that can narrow or widen what it takes.

When a frame is kept, the block pulses a load strobe for one cycle. With the strobe it reports the target buffer and the index of the filter that matched, and it sets that buffer's receive flag. A buffer whose flag is still set is locked. If rollover is enabled, a frame meant for a locked buffer 0 goes to buffer 1. Otherwise the frame is dropped and a sticky overflow flag is raised. The receive flags and the overflow flags are cleared through dedicated pulse inputs.

Top module: `can_rx_steer`

## Requirements
- R1: A mask bit of 1 requires the identifier bit to equal the filter bit, and a mask bit of 0 makes that bit don't-care. An extended frame compares all 29 bits of `frm_id`. A standard frame carries its 11-bit identifier in `frm_id[10:0]`, which is compared against bits [28:18] of the mask and the filter.
- R2: A filter whose bit in `filt_ext` is 1 matches only extended frames (`frm_ide`=1). A filter whose bit is 0 matches only standard frames.
- R3: The receive mode of each buffer is encoded as follows: 2'b11 takes every frame without filtering; 2'b10 filters extended frames and rejects standard ones; 2'b01 filters standard frames and rejects extended ones; 2'b00 filters both kinds.
- R4: Buffer 0 is evaluated first. When buffer 0 accepts a frame, buffer 1 is not considered, so a frame is loaded into at most one buffer.
- R5: `hit_code` gives the index of the matching filter: 0–1 for buffer 0 and 2–5 for buffer 1. Within a buffer, the lowest-indexed matching filter wins. A buffer in mode 2'b11 reports code 7.
- R6: `load_stb` is a one-cycle pulse in the cycle after the accepted `frm_valid`. `load_buf` (0 or 1) and `hit_code` update with the pulse and hold their values until the next load.
- R7: A load sets `rx_flag[load_buf]` in the same cycle as the strobe. `flag_clr[b]` clears flag b, and a simultaneous load wins. A frame is never loaded into a buffer whose flag was set when the frame arrived.
- R8: When `roll_en` is 1 and a frame accepted by buffer 0 finds `rx_flag[0]` set and `rx_flag[1]` clear, the frame goes to buffer 1 and keeps buffer 0's filter code.
- R9: When the chosen buffer is locked and no rollover applies, the frame is dropped (no strobe) and `ovf_flag` for that buffer is set. The flag is sticky until `ovf_clr[b]`, and a simultaneous set wins.
- R10: A frame with `frm_err`=1 is accepted only by a buffer in mode 2'b11. A buffer in any other mode rejects it.
- R11: After reset, `load_stb`, `load_buf`, `hit_code`, `rx_flag` and `ovf_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | One-cycle pulse: a completed frame is present |
| frm_id | input | 29 | Identifier (standard frames use bits [10:0]) |
| frm_ide | input | 1 | 1 = extended frame, 0 = standard frame |
| frm_err | input | 1 | Frame ended in error |
| mask0 | input | 29 | Acceptance mask for buffer 0 |
| mask1 | input | 29 | Acceptance mask for buffer 1 |
| filt_bank | input | 174 | Six 29-bit filters; filter f is at bits [29f+28:29f] |
| filt_ext | input | 6 | Per-filter frame type select (1 = extended only) |
| mode0 | input | 2 | Receive mode of buffer 0 |
| mode1 | input | 2 | Receive mode of buffer 1 |
| roll_en | input | 1 | Enable rollover from buffer 0 to buffer 1 |
| flag_clr | input | 2 | Clear pulses for the receive flags |
| ovf_clr | input | 2 | Clear pulses for the overflow flags |
| load_stb | output | 1 | One-cycle load strobe |
| load_buf | output | 1 | Target buffer of the last load |
| hit_code | output | 3 | Filter-hit code of the last load |
| rx_flag | output | 2 | Receive-full flags per buffer |
| ovf_flag | output | 2 | Overflow flags per buffer |

## Verification
The bench builds the block with its default parameters: 29-bit identifiers, 11-bit standard identifiers, and two plus four filters. With these values every hit code from 0 to 5, the accept-all code 7 and the standard/extended alignment boundary at bit 18 can all be reached. Duplicate filters in both banks exercise the precedence between buffers and the lowest-index-wins rule. A second phase uses pseudo-random frames drawn from a small identifier pool, together with random clear pulses and periodic changes to the modes and the rollover setting. This drives rollover, overflow, lockout and error frames in many different orderings.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;
  typedef enum logic [1:0] {
    RXM_BOTH = 2'b00,
    RXM_STD  = 2'b01,
    RXM_EXT  = 2'b10,
    RXM_ALL  = 2'b11
  } rx_mode_e;
endpackage

// File: rtl/can_buf_match.sv
// Acceptance decision for one receive buffer: mode gate, then its filter bank.
module can_buf_match #(
  parameter int ID_W  = 29,
  parameter int STD_W = 11,
  parameter int NF    = 2,
  parameter int BASE  = 0,
  parameter int HIT_W = 3
) (
  input  logic [ID_W-1:0]    id,
  input  logic               ide,
  input  logic               err,
  input  logic [ID_W-1:0]    mask,
  input  logic [NF*ID_W-1:0] filt,
  input  logic [NF-1:0]      exide,
  input  logic [1:0]         mode,
  output logic               accept,
  output logic [HIT_W-1:0]   hit_idx
);
  import can_acc_pkg::*;

  localparam int LOW_W = ID_W - STD_W;
  localparam logic [HIT_W-1:0] ALL_CODE = '1;

  // A standard identifier is moved up to the top STD_W bits.
  function automatic logic [ID_W-1:0] align_key(input logic [ID_W-1:0] raw, input logic ext);
    return ext ? raw : {raw[STD_W-1:0], {LOW_W{1'b0}}};
  endfunction

  // For a standard frame, only the top STD_W mask bits take part.
  function automatic logic [ID_W-1:0] eff_mask(input logic [ID_W-1:0] m, input logic ext);
    return ext ? m : {m[ID_W-1 -: STD_W], {LOW_W{1'b0}}};
  endfunction

  function automatic logic type_ok(input logic [1:0] md, input logic ext);
    case (rx_mode_e'(md))
      RXM_EXT: return ext;
      RXM_STD: return !ext;
      default: return 1'b1;
    endcase
  endfunction

  logic [ID_W-1:0] key, emask;
  logic [NF-1:0]   f_hit;

  assign key   = align_key(id, ide);
  assign emask = eff_mask(mask, ide);

  for (genvar g = 0; g < NF; g++) begin : g_filt
    assign f_hit[g] = (exide[g] == ide) &&
                      (((key ^ align_key(filt[g*ID_W +: ID_W], 1'b1)) & emask) == '0);
  end

  always_comb begin
    accept  = 1'b0;
    hit_idx = ALL_CODE;
    if (mode == RXM_ALL) begin
      accept = 1'b1;
    end else if (!err && type_ok(mode, ide)) begin
      // Walk downward so the lowest matching index is the one kept.
      for (int i = NF - 1; i >= 0; i--) begin
        if (f_hit[i]) begin
          accept  = 1'b1;
          hit_idx = HIT_W'(BASE + i);
        end
      end
    end
  end

  // R10: an errored frame gets through only in accept-all mode.
  always_comb begin
    if (accept && err)
      p_err_only_all_r10: assert (mode == RXM_ALL);
  end
endmodule

// File: rtl/can_rx_flags.sv
// Receive-full and overflow flags. A set in the same cycle as a clear wins.
module can_rx_flags #(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_flag,
  input  logic [NB-1:0] clr_flag,
  input  logic [NB-1:0] set_ovf,
  input  logic [NB-1:0] clr_ovf,
  output logic [NB-1:0] rx_flag,
  output logic [NB-1:0] ovf_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_flag  <= '0;
      ovf_flag <= '0;
    end else begin
      rx_flag  <= (rx_flag & ~clr_flag) | set_flag;
      ovf_flag <= (ovf_flag & ~clr_ovf) | set_ovf;
    end
  end

  // R9: an overflow that is being set must read as set on the next cycle.
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_ovf[0] |=> ovf_flag[0]);
endmodule

// File: rtl/can_rx_steer.sv
module can_rx_steer #(
  parameter int ID_W  = 29,
  parameter int STD_W = 11,
  parameter int N0    = 2,
  parameter int N1    = 4,
  parameter int NF    = N0 + N1,
  parameter int HIT_W = $clog2(NF + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_valid,
  input  logic [ID_W-1:0]    frm_id,
  input  logic               frm_ide,
  input  logic               frm_err,
  input  logic [ID_W-1:0]    mask0,
  input  logic [ID_W-1:0]    mask1,
  input  logic [NF*ID_W-1:0] filt_bank,
  input  logic [NF-1:0]      filt_ext,
  input  logic [1:0]         mode0,
  input  logic [1:0]         mode1,
  input  logic               roll_en,
  input  logic [1:0]         flag_clr,
  input  logic [1:0]         ovf_clr,
  output logic               load_stb,
  output logic               load_buf,
  output logic [HIT_W-1:0]   hit_code,
  output logic [1:0]         rx_flag,
  output logic [1:0]         ovf_flag
);
  // Named decision wires, shared by the steering logic and the assertions.
  logic             acc0, acc1;
  logic [HIT_W-1:0] code0, code1;
  logic             want_load, tgt, roll_used;
  logic [HIT_W-1:0] tgt_code;
  logic [1:0]       set_flag, set_ovf;

  can_buf_match #(.ID_W(ID_W), .STD_W(STD_W), .NF(N0), .BASE(0), .HIT_W(HIT_W)) u_m0 (
    .id(frm_id), .ide(frm_ide), .err(frm_err), .mask(mask0),
    .filt(filt_bank[N0*ID_W-1:0]), .exide(filt_ext[N0-1:0]), .mode(mode0),
    .accept(acc0), .hit_idx(code0));

  can_buf_match #(.ID_W(ID_W), .STD_W(STD_W), .NF(N1), .BASE(N0), .HIT_W(HIT_W)) u_m1 (
    .id(frm_id), .ide(frm_ide), .err(frm_err), .mask(mask1),
    .filt(filt_bank[NF*ID_W-1:N0*ID_W]), .exide(filt_ext[NF-1:N0]), .mode(mode1),
    .accept(acc1), .hit_idx(code1));

  always_comb begin
    want_load = 1'b0;
    tgt       = 1'b0;
    tgt_code  = code0;
    roll_used = 1'b0;
    set_ovf   = 2'b00;
    if (frm_valid) begin
      if (acc0) begin
        if (!rx_flag[0]) begin
          want_load = 1'b1;
        end else if (roll_en && !rx_flag[1]) begin
          want_load = 1'b1;
          tgt       = 1'b1;
          roll_used = 1'b1;
        end else begin
          set_ovf[0] = 1'b1;
        end
      end else if (acc1) begin
        tgt_code = code1;
        if (!rx_flag[1]) begin
          want_load = 1'b1;
          tgt       = 1'b1;
        end else begin
          set_ovf[1] = 1'b1;
        end
      end
    end
    set_flag = want_load ? (tgt ? 2'b10 : 2'b01) : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_stb <= 1'b0;
      load_buf <= 1'b0;
      hit_code <= '0;
    end else begin
      load_stb <= want_load;
      if (want_load) begin
        load_buf <= tgt;
        hit_code <= tgt_code;
      end
    end
  end

  can_rx_flags #(.NB(2)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_flag(set_flag), .clr_flag(flag_clr),
    .set_ovf(set_ovf), .clr_ovf(ovf_clr), .rx_flag(rx_flag), .ovf_flag(ovf_flag));

  p_stb_follows_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> $past(frm_valid));
  p_flag_on_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> rx_flag[load_buf]);
  p_no_load_locked0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && !load_buf) |-> !$past(rx_flag[0]));
  p_no_load_locked1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && load_buf) |-> !$past(rx_flag[1]));
  p_buf0_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && !load_buf) |-> (hit_code < HIT_W'(N0) || hit_code == '1));
  p_roll_only_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && load_buf && hit_code < HIT_W'(N0)) |-> ($past(roll_en) && $past(rx_flag[0])));
  p_ovf_rise_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovf_flag[0]) || $rose(ovf_flag[1])) |-> !load_stb);
  p_single_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_flag | set_ovf));
endmodule

// File: tb/tb_can_rx_steer.sv
module tb_can_rx_steer;
  localparam int IW = 29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_valid = 1'b0, frm_ide = 1'b0, frm_err = 1'b0, roll_en = 1'b0;
  logic [IW-1:0] frm_id = '0, mask0 = '0, mask1 = '0;
  logic [6*IW-1:0] filt_bank = '0;
  logic [5:0] filt_ext = '0;
  logic [1:0] mode0 = 2'b00, mode1 = 2'b00, flag_clr = 2'b00, ovf_clr = 2'b00;
  logic load_stb, load_buf;
  logic [2:0] hit_code;
  logic [1:0] rx_flag, ovf_flag;

  // staged configuration, applied inside step()
  logic [1:0] n_mode0 = 2'b00, n_mode1 = 2'b00;
  logic n_roll = 1'b0;

  // reference model state
  logic m_stb = 1'b0, m_buf = 1'b0;
  logic [2:0] m_code = 3'd0;
  logic [1:0] m_flag = 2'b00, m_ovf = 2'b00;

  int checks = 0, errors = 0;
  string last_req = "R11";

  always #10 clk = ~clk;

  can_rx_steer dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_id(frm_id), .frm_ide(frm_ide),
    .frm_err(frm_err), .mask0(mask0), .mask1(mask1), .filt_bank(filt_bank),
    .filt_ext(filt_ext), .mode0(mode0), .mode1(mode1), .roll_en(roll_en),
    .flag_clr(flag_clr), .ovf_clr(ovf_clr), .load_stb(load_stb), .load_buf(load_buf),
    .hit_code(hit_code), .rx_flag(rx_flag), .ovf_flag(ovf_flag));

  // Returns the filter code a buffer takes the current frame with, or -1.
  function automatic int pick(input int b);
    int lo = (b == 0) ? 0 : 2;
    int hi = (b == 0) ? 2 : 6;
    logic [1:0] md = (b == 0) ? mode0 : mode1;
    logic [IW-1:0] m = (b == 0) ? mask0 : mask1;
    if (md == 2'b11) return 7;
    if (frm_err) return -1;
    if (md == 2'b10 && !frm_ide) return -1;
    if (md == 2'b01 && frm_ide) return -1;
    for (int f = lo; f < hi; f++) begin
      logic [IW-1:0] fv = filt_bank[f*IW +: IW];
      bit ok = 1;
      if (filt_ext[f] != frm_ide) continue;
      if (frm_ide) begin
        for (int k = 0; k < IW; k++) if (m[k] && fv[k] != frm_id[k]) ok = 0;
      end else begin
        for (int k = 0; k < 11; k++) if (m[18+k] && fv[18+k] != frm_id[k]) ok = 0;
      end
      if (ok) return f;
    end
    return -1;
  endfunction

  task automatic model_update();
    logic [1:0] nf = m_flag & ~flag_clr;
    logic [1:0] no = m_ovf & ~ovf_clr;
    int c0, c1;
    m_stb = 1'b0;
    if (frm_valid) begin
      c0 = pick(0);
      if (c0 >= 0) begin
        if (!m_flag[0]) begin m_stb = 1; m_buf = 0; m_code = 3'(c0); nf[0] = 1; end
        else if (roll_en && !m_flag[1]) begin m_stb = 1; m_buf = 1; m_code = 3'(c0); nf[1] = 1; end
        else no[0] = 1;
      end else begin
        c1 = pick(1);
        if (c1 >= 0) begin
          if (!m_flag[1]) begin m_stb = 1; m_buf = 1; m_code = 3'(c1); nf[1] = 1; end
          else no[1] = 1;
        end
      end
    end
    m_flag = nf;
    m_ovf = no;
  endtask

  task automatic compare(input string req);
    checks++;
    if (load_stb !== m_stb || load_buf !== m_buf || hit_code !== m_code ||
        rx_flag !== m_flag || ovf_flag !== m_ovf) begin
      errors++;
      $display("FAIL %s: actual stb=%b buf=%b code=%0d flag=%b ovf=%b expected stb=%b buf=%b code=%0d flag=%b ovf=%b",
               req, load_stb, load_buf, hit_code, rx_flag, ovf_flag,
               m_stb, m_buf, m_code, m_flag, m_ovf);
    end
  endtask

  task automatic step(input string req, input logic v, input logic [IW-1:0] id,
                      input logic ide, input logic err, input logic [1:0] fc, input logic [1:0] oc);
    @(negedge clk);
    compare(last_req);
    last_req = req;
    mode0 = n_mode0; mode1 = n_mode1; roll_en = n_roll;
    frm_valid = v; frm_id = id; frm_ide = ide; frm_err = err;
    flag_clr = fc; ovf_clr = oc;
    model_update();
  endtask

  task automatic clear_all(input string req);
    step(req, 0, '0, 0, 0, 2'b11, 2'b11);
  endtask

  function automatic logic [IW-1:0] sk(input logic [10:0] s);
    return {s, 18'd0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R6: watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [IW-1:0] pool_id [7];
    logic pool_ide [7];
    mask0 = '1;
    mask1 = {11'h7F0, 18'h3FFFF};
    filt_bank[0*IW +: IW] = sk(11'h123);      filt_ext[0] = 0;
    filt_bank[1*IW +: IW] = 29'h1ABCDEF0;     filt_ext[1] = 1;
    filt_bank[2*IW +: IW] = sk(11'h450);      filt_ext[2] = 0;
    filt_bank[3*IW +: IW] = sk(11'h450);      filt_ext[3] = 0;
    filt_bank[4*IW +: IW] = 29'h00000055;     filt_ext[4] = 1;
    filt_bank[5*IW +: IW] = sk(11'h123);      filt_ext[5] = 0;

    // R11: reset state
    repeat (3) @(negedge clk);
    compare("R11");
    @(negedge clk);
    rst_n = 1'b1;

    step("R4", 1, 29'h123, 0, 0, 2'b00, 2'b00);        // f0 and f5 match: buffer 0, code 0
    clear_all("R7");
    step("R1", 1, 29'h45A, 0, 0, 2'b00, 2'b00);        // low nibble don't-care -> code 2 (R5)
    step("R9", 1, 29'h00000055, 1, 0, 2'b00, 2'b00);   // buffer 1 locked -> ovf1
    step("R9", 0, '0, 0, 0, 2'b00, 2'b00);             // overflow stays set
    clear_all("R9");
    step("R2", 1, 29'h123, 1, 0, 2'b00, 2'b00);        // extended 0x123 hits no standard filter
    step("R1", 1, 29'h1ABCDEF0, 1, 0, 2'b00, 2'b00);   // buffer 0, code 1
    step("R7", 1, 29'h123, 0, 0, 2'b00, 2'b00);        // buffer 0 locked, no roll -> ovf0
    clear_all("R7");
    step("R7", 1, 29'h123, 0, 0, 2'b00, 2'b00);
    n_roll = 1;
    step("R8", 1, 29'h123, 0, 0, 2'b00, 2'b00);        // rollover into buffer 1, code 0
    step("R9", 1, 29'h123, 0, 0, 2'b00, 2'b00);        // both full -> ovf0
    clear_all("R8");
    step("R7", 1, 29'h45A, 0, 0, 2'b10, 2'b00);        // load wins over clear
    clear_all("R7");
    n_roll = 0; n_mode0 = 2'b10;
    step("R3", 1, 29'h123, 0, 0, 2'b00, 2'b00);        // buf0 extended only -> f5, code 5
    clear_all("R3");
    n_mode0 = 2'b00; n_mode1 = 2'b01;
    step("R3", 1, 29'h00000055, 1, 0, 2'b00, 2'b00);   // buf1 standard only -> rejected
    n_mode1 = 2'b00; n_mode0 = 2'b11;
    step("R10", 1, 29'h0F0F0F0, 1, 1, 2'b00, 2'b00);   // accept-all takes errored frame, code 7
    clear_all("R10");
    n_mode0 = 2'b00;
    step("R10", 1, 29'h123, 0, 1, 2'b00, 2'b00);       // errored frame rejected
    n_mode1 = 2'b11;
    step("R5", 1, 29'h3FF, 0, 0, 2'b00, 2'b00);        // buffer 1 accept-all, code 7
    clear_all("R5");
    n_mode1 = 2'b00;

    pool_id[0] = 29'h123;      pool_ide[0] = 0;
    pool_id[1] = 29'h45A;      pool_ide[1] = 0;
    pool_id[2] = 29'h450;      pool_ide[2] = 0;
    pool_id[3] = 29'h00000055; pool_ide[3] = 1;
    pool_id[4] = 29'h1ABCDEF0; pool_ide[4] = 1;
    pool_id[5] = 29'h123;      pool_ide[5] = 1;
    pool_id[6] = 29'h7FF;      pool_ide[6] = 0;
    for (int n = 0; n < 600; n++) begin
      int p = $urandom_range(0, 6);
      if (n % 75 == 0) begin
        n_mode0 = 2'($urandom_range(0, 3));
        n_mode1 = 2'($urandom_range(0, 3));
        n_roll = 1'($urandom_range(0, 1));
      end
      step("R6", ($urandom_range(0, 3) != 0), pool_id[p], pool_ide[p],
           ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 2) == 0) ? 2'($urandom_range(0, 3)) : 2'b00,
           ($urandom_range(0, 4) == 0) ? 2'($urandom_range(0, 3)) : 2'b00);
    end
    step("R6", 0, '0, 0, 0, 2'b00, 2'b00);
    @(negedge clk);
    compare(last_req);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule